// File: doc/BRIEF.md
# Dual-Mode Floppy Controller Register Front-End

This block is the software-visible register face of a floppy disk controller. After reset it runs in a legacy soft-switch mode. In that mode the address of each bus access, read or write, flips one of eight single-bit control latches. When two of those latches, Q6 and Q7, are both set, a write also lands in one of two byte registers: the legacy data register or the legacy mode register. The motor latch chooses between them.

A fixed four-byte unlock pattern written to the legacy mode register moves the block into an enhanced register map. The block then stays in that map until the next reset. In the enhanced map it holds a phase register and a mode register. The mode register has separate clear-bits and set-bits write ports. A handshake register answers a drive-present query from the phase value.

The bus is a plain single-cycle strobe interface with no back-pressure: every strobe is taken in the cycle it is asserted, and read data is combinational from the current address. The register index is address bits [12:9], which gives 16 slots in a 0x2000-byte window. The mode flag, the latches and the byte registers are brought out as status pins. Data transfer, CRC, mark handling, motor control and media access sit outside this block.

Top module: `fdc_regfront`

## Requirements
- R1: After reset the block is in legacy mode (`enh_mode`=0), and `latch_q`, `lg_data`, `lg_mode`, `ex_mode` and the phase register are all 0.
- R2: In legacy mode, a read or a write at index r = addr[12:9] sets latch bit r>>1 to r[0] on that clock edge and leaves the other latches unchanged. The latch bits are 0..3 phase lines, 4 motor, 5 drive select, 6 Q6 and 7 Q7.
- R3: In legacy mode `bus_rdata` is always 0x00.
- R4: In legacy mode, a write loads `lg_data` when Q6, Q7 and motor are all 1 after that same access has updated the latches. `lg_data` changes on no other event.
- R5: In legacy mode, a write loads `lg_mode` when Q6 and Q7 are 1 and motor is 0 after that access's latch update. Any other write leaves `lg_mode` unchanged.
- R6: Each value loaded into `lg_mode` is compared with the next byte of the pattern 0x57, 0x17, 0x57, 0x57. A match advances the position, and a mismatch keeps it where it is. A match on the fourth byte raises `enh_mode` at that edge and returns the position to the start.
- R7: Once `enh_mode` is 1 it stays 1 until reset. `latch_q`, `lg_data` and `lg_mode` then no longer change.
- R8: In enhanced mode, a write at index 4 loads the phase register, and a read at index 12 returns it.
- R9: In enhanced mode, a write at index 6 clears the `ex_mode` bits that are 1 in the write data. A write at index 7 sets those bits.
- R10: In enhanced mode, a read at index 15 returns 0x08 when the phase register is 0x77 and 0x00 otherwise. Reads at indices other than 12 and 15 return 0x00.
- R11: In enhanced mode, writes at indices 0, 1, 2, 3 and 5 change neither the phase register nor `ex_mode`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 13 | Byte address; bits [12:9] select the register slot |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for the current address |
| enh_mode | output | 1 | 1 once the enhanced register map is active |
| latch_q | output | 8 | Legacy control latches |
| lg_data | output | 8 | Legacy data register |
| lg_mode | output | 8 | Legacy mode register |
| ex_mode | output | 8 | Enhanced mode register |

## Verification
Several properties are checked on every cycle:
- legacy read data stays zero;
- each legacy access writes the addressed latch bit;
- the enhanced flag never drops, and it only rises on a write;
- latches and legacy registers stay frozen in enhanced mode;
- the clear and set ports act on the addressed bits;
- the handshake read only yields 0x00 or 0x08;
- ignored indices leave `ex_mode` alone.

Some behaviours only the bench's scenarios can show. These are the ordering of the unlock pattern, including the rule that a mismatched byte holds the detector position, and the use of the post-update latch values when a write is routed. They also include the round trip of the phase value through the read path and the exact handshake answer.

// File: rtl/fdc_pkg.sv
package fdc_pkg;
  // register slot indices that the behaviour depends on
  localparam int unsigned IX_PHASE_WR = 4;
  localparam int unsigned IX_MODE_CLR = 6;
  localparam int unsigned IX_MODE_SET = 7;
  localparam int unsigned IX_PHASE_RD = 12;
  localparam int unsigned IX_HSHK     = 15;

  // latch positions
  localparam int unsigned LT_MOTOR = 4;
  localparam int unsigned LT_Q6    = 6;
  localparam int unsigned LT_Q7    = 7;

  localparam int unsigned SEQ_LEN   = 4;
  localparam int unsigned SEQ_W     = $clog2(SEQ_LEN);
  localparam logic [7:0]  SENSE_BIT = 8'h08;
  localparam logic [7:0]  PRESENT_Q = 8'h77;

  typedef enum logic { MAP_LEGACY = 1'b0, MAP_ENH = 1'b1 } map_e;

  function automatic logic [7:0] unlock_byte(input logic [SEQ_W-1:0] pos);
    unlock_byte = (pos == SEQ_W'(1)) ? 8'h17 : 8'h57;
  endfunction
endpackage

// File: rtl/fdc_latch_bank.sv
module fdc_latch_bank #(
  parameter int unsigned IDX_W = 4,
  localparam int unsigned NL   = 2 ** (IDX_W - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_en,
  input  logic [IDX_W-1:0] idx,
  output logic [NL-1:0]    lat_q,
  output logic [NL-1:0]    lat_nxt
);
  for (genvar g = 0; g < NL; g++) begin : g_lat
    always_comb begin
      lat_nxt[g] = lat_q[g];
      if (acc_en && (idx[IDX_W-1:1] == (IDX_W-1)'(g))) lat_nxt[g] = idx[0];
    end
    always_ff @(posedge clk) begin
      if (!rst_n) lat_q[g] <= 1'b0;
      else        lat_q[g] <= lat_nxt[g];
    end
  end
endmodule

// File: rtl/fdc_unlock_det.sv
module fdc_unlock_det
  import fdc_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] val,
  output logic          unlock
);
  logic [SEQ_W-1:0] pos_q;
  logic             hit;

  assign hit    = push && (val[7:0] == unlock_byte(pos_q));
  assign unlock = hit && (pos_q == SEQ_W'(SEQ_LEN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)      pos_q <= '0;
    else if (unlock) pos_q <= '0;
    else if (hit)    pos_q <= pos_q + SEQ_W'(1);
  end
endmodule

// File: rtl/fdc_enh_regs.sv
module fdc_enh_regs
  import fdc_pkg::*;
#(
  parameter int unsigned IDX_W = 4,
  parameter int unsigned DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             wr,
  input  logic [IDX_W-1:0] idx,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    mode_q,
  output logic [DW-1:0]    rdata
);
  logic [DW-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
      mode_q  <= '0;
    end else if (en && wr) begin
      if (idx == IDX_W'(IX_PHASE_WR)) phase_q <= wdata;
      if (idx == IDX_W'(IX_MODE_CLR)) mode_q  <= mode_q & ~wdata;
      if (idx == IDX_W'(IX_MODE_SET)) mode_q  <= mode_q | wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (en) begin
      if (idx == IDX_W'(IX_PHASE_RD)) rdata = phase_q;
      if (idx == IDX_W'(IX_HSHK) && phase_q[7:0] == PRESENT_Q) rdata = DW'(SENSE_BIT);
    end
  end
endmodule

// File: rtl/fdc_regfront.sv
module fdc_regfront
  import fdc_pkg::*;
#(
  parameter int unsigned SHIFT = 9,
  parameter int unsigned IDX_W = 4,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = SHIFT + IDX_W,
  localparam int unsigned NL   = 2 ** (IDX_W - 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          enh_mode,
  output logic [NL-1:0] latch_q,
  output logic [DW-1:0] lg_data,
  output logic [DW-1:0] lg_mode,
  output logic [DW-1:0] ex_mode
);
  map_e             map_q;
  logic [IDX_W-1:0] idx;
  logic [NL-1:0]    lat_nxt;
  logic             legacy, wr_q67, ld_data, ld_mode, unlock;
  logic             unused_low_bits;

  assign idx             = bus_addr[AW-1:SHIFT];
  assign unused_low_bits = ^bus_addr[SHIFT-1:0];
  assign legacy          = (map_q == MAP_LEGACY);
  assign enh_mode        = (map_q == MAP_ENH);

  fdc_latch_bank #(.IDX_W(IDX_W)) u_lat (
    .clk(clk), .rst_n(rst_n), .acc_en(legacy && (bus_wr || bus_rd)),
    .idx(idx), .lat_q(latch_q), .lat_nxt(lat_nxt)
  );

  // routing uses the latch values after this access's own update
  assign wr_q67  = legacy && bus_wr && lat_nxt[LT_Q6] && lat_nxt[LT_Q7];
  assign ld_data = wr_q67 && lat_nxt[LT_MOTOR];
  assign ld_mode = wr_q67 && !lat_nxt[LT_MOTOR];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lg_data <= '0;
      lg_mode <= '0;
    end else begin
      if (ld_data) lg_data <= bus_wdata;
      if (ld_mode) lg_mode <= bus_wdata;
    end
  end

  fdc_unlock_det #(.DW(DW)) u_det (
    .clk(clk), .rst_n(rst_n), .push(ld_mode), .val(bus_wdata), .unlock(unlock)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      map_q <= MAP_LEGACY;
    else if (unlock) map_q <= MAP_ENH;
  end

  fdc_enh_regs #(.IDX_W(IDX_W), .DW(DW)) u_enh (
    .clk(clk), .rst_n(rst_n), .en(enh_mode), .wr(bus_wr), .idx(idx),
    .wdata(bus_wdata), .mode_q(ex_mode), .rdata(bus_rdata)
  );
endmodule

// File: rtl/fdc_regfront_chk.sv
module fdc_regfront_chk #(
  parameter int unsigned SHIFT = 9,
  parameter int unsigned IDX_W = 4,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = SHIFT + IDX_W,
  localparam int unsigned NL   = 2 ** (IDX_W - 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] bus_rdata,
  input logic          enh_mode,
  input logic [NL-1:0] latch_q,
  input logic [DW-1:0] lg_data,
  input logic [DW-1:0] lg_mode,
  input logic [DW-1:0] ex_mode
);
  logic [IDX_W-1:0] cidx;
  logic             unused_chk_bits;
  assign cidx            = bus_addr[AW-1:SHIFT];
  assign unused_chk_bits = ^bus_addr[SHIFT-1:0];

  p_legacy_rdata_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !enh_mode |-> bus_rdata == '0);

  p_latch_update_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!enh_mode && (bus_wr || bus_rd)) |=> latch_q[$past(cidx[IDX_W-1:1])] == $past(cidx[0]));

  p_data_only_on_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lg_data) |-> $past(bus_wr));

  p_unlock_on_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enh_mode) |-> $past(bus_wr));

  p_enh_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    enh_mode |=> enh_mode);

  p_enh_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    enh_mode |=> ($stable(latch_q) && $stable(lg_data) && $stable(lg_mode)));

  p_mode_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (enh_mode && bus_wr && cidx == IDX_W'(7)) |=> (ex_mode & $past(bus_wdata)) == $past(bus_wdata));

  p_mode_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (enh_mode && bus_wr && cidx == IDX_W'(6)) |=> (ex_mode & $past(bus_wdata)) == '0);

  p_hshk_value_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (enh_mode && cidx == IDX_W'(15)) |-> (bus_rdata == DW'(8'h08) || bus_rdata == '0));

  p_ignored_idx_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (enh_mode && bus_wr && (cidx <= IDX_W'(3) || cidx == IDX_W'(5))) |=> $stable(ex_mode));
endmodule

bind fdc_regfront fdc_regfront_chk #(.SHIFT(SHIFT), .IDX_W(IDX_W), .DW(DW)) u_chk (.*);

// File: tb/fdc_regfront_bench.sv
module fdc_regfront_bench;
  localparam int unsigned CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata, lg_data, lg_mode, ex_mode, latch_q;
  logic        enh_mode;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // reference model state
  logic [7:0] m_lat, m_data, m_lmode, m_emode, m_phase;
  logic       m_enh;
  int         m_pos;

  always #(CLK_PERIOD/2) clk = ~clk;

  fdc_regfront u_fdc_regfront (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rdata(logic [3:0] ix);
    if (!m_enh) return 8'h00;
    if (ix == 4'd12) return m_phase;
    if (ix == 4'd15) return (m_phase == 8'h77) ? 8'h08 : 8'h00;
    return 8'h00;
  endfunction

  function automatic logic [7:0] pat(int p);
    return (p == 1) ? 8'h17 : 8'h57;
  endfunction

  task automatic model_step(logic [3:0] ix, logic wr, logic rd, logic [7:0] wd);
    if (!m_enh) begin
      if (wr || rd) m_lat[ix[3:1]] = ix[0];
      if (wr && m_lat[6] && m_lat[7]) begin
        if (m_lat[4]) m_data = wd;
        else begin
          m_lmode = wd;
          if (wd == pat(m_pos)) begin
            if (m_pos == 3) begin m_enh = 1'b1; m_pos = 0; end
            else m_pos++;
          end
        end
      end
    end else if (wr) begin
      if (ix == 4'd4) m_phase = wd;
      if (ix == 4'd6) m_emode = m_emode & ~wd;
      if (ix == 4'd7) m_emode = m_emode | wd;
    end
  endtask

  task automatic check_state();
    chk("R2 latch_q", latch_q, m_lat);
    chk("R6 enh_mode", {7'd0, enh_mode}, {7'd0, m_enh});
    chk("R4 lg_data", lg_data, m_data);
    chk("R5 lg_mode", lg_mode, m_lmode);
    chk("R9 ex_mode", ex_mode, m_emode);
  endtask

  // drive one access after a falling edge, check read data, then state
  task automatic acc(logic [3:0] ix, logic wr, logic rd, logic [7:0] wd);
    @(negedge clk);
    bus_addr = {ix, 9'h0A5 & {9{ix[0]}}};
    bus_wr = wr; bus_rd = rd; bus_wdata = wd;
    #1;
    if (rd) chk(m_enh ? "R10 rdata" : "R3 rdata", bus_rdata, exp_rdata(ix));
    @(posedge clk);
    #1;
    bus_wr = 1'b0; bus_rd = 1'b0;
    model_step(ix, wr, rd, wd);
    check_state();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0F11));
    m_lat = '0; m_data = '0; m_lmode = '0; m_emode = '0; m_phase = '0;
    m_enh = 1'b0; m_pos = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    check_state();
    chk("R1 rdata", bus_rdata, 8'h00);

    // R2 single latch writes via reads and writes
    acc(4'd1, 1'b0, 1'b1, 8'h00);
    acc(4'd5, 1'b1, 1'b0, 8'h3C);
    acc(4'd4, 1'b0, 1'b1, 8'h00);
    // R4: Q6,Q7,motor set; data lands in lg_data
    acc(4'd13, 1'b0, 1'b1, 8'h00);
    acc(4'd9,  1'b0, 1'b1, 8'h00);
    acc(4'd15, 1'b1, 1'b0, 8'h5A);
    // R5: motor off then write to the mode register
    acc(4'd8, 1'b0, 1'b1, 8'h00);
    acc(4'd15, 1'b1, 1'b0, 8'h66);

    // random legacy traffic, rarely touching Q6/Q7 routes
    for (int i = 0; i < 300; i++) begin
      logic [3:0] ix = 4'($urandom_range(0, 15));
      logic w = 1'($urandom_range(0, 1));
      acc(ix, w, !w, 8'($urandom));
    end

    // R6 unlock: clear motor, set Q6 and Q7, then pattern with a held mismatch
    if (!m_enh) begin
      acc(4'd8,  1'b0, 1'b1, 8'h00);
      acc(4'd13, 1'b0, 1'b1, 8'h00);
      while (m_pos != 0) acc(4'd15, 1'b1, 1'b0, pat(m_pos));
      if (!m_enh) begin
        acc(4'd15, 1'b1, 1'b0, 8'h57);
        acc(4'd15, 1'b1, 1'b0, 8'h17);
        acc(4'd15, 1'b1, 1'b0, 8'h33);   // mismatch keeps the position
        acc(4'd15, 1'b1, 1'b0, 8'h57);
        chk("R6 still legacy", {7'd0, enh_mode}, 8'h00);
        acc(4'd15, 1'b1, 1'b0, 8'h57);
        chk("R6 entered enhanced", {7'd0, enh_mode}, 8'h01);
      end
    end

    // R7: legacy routes are dead now
    acc(4'd15, 1'b1, 1'b0, 8'hAA);
    acc(4'd0,  1'b0, 1'b1, 8'h00);
    chk("R7 sticky", {7'd0, enh_mode}, 8'h01);

    // R8 / R10 phase and handshake
    acc(4'd4,  1'b1, 1'b0, 8'h77);
    acc(4'd15, 1'b0, 1'b1, 8'h00);
    acc(4'd12, 1'b0, 1'b1, 8'h00);
    chk("R8 phase readback", exp_rdata(4'd12), 8'h77);
    acc(4'd13, 1'b0, 1'b1, 8'h00);
    acc(4'd4,  1'b1, 1'b0, 8'h76);
    acc(4'd15, 1'b0, 1'b1, 8'h00);

    // R9 set then clear
    acc(4'd7, 1'b1, 1'b0, 8'hF0);
    acc(4'd6, 1'b1, 1'b0, 8'h30);
    chk("R9 ex_mode after set/clear", ex_mode, 8'hC0);

    // R11 ignored indices
    for (int k = 0; k < 6; k++) begin
      if (k != 4) acc(4'(k), 1'b1, 1'b0, 8'hFF);
    end
    acc(4'd12, 1'b0, 1'b1, 8'h00);
    chk("R11 ex_mode unchanged", ex_mode, 8'hC0);

    // random enhanced traffic
    for (int i = 0; i < 300; i++) begin
      logic [3:0] ix = 4'($urandom_range(0, 15));
      logic w = 1'($urandom_range(0, 1));
      acc(ix, w, !w, ($urandom_range(0, 3) == 0) ? 8'h77 : 8'($urandom));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule